// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Controller

This block is the bus-facing side of a small serial memory. It watches a two-wire bus (a clock line and a bidirectional data line) through synchronisers on the system clock. It recognises start and stop conditions and decodes a device-select byte made of a fixed `1010` type code, three pin-strapped select bits and a read/write flag. It answers by pulling the data line low through an open-drain enable. A write carries a 16-bit memory pointer, most significant byte first, then one data byte. The byte reaches the internal array only when the controller closes the transfer with a stop. A programming interval of fixed length follows, during which the block ignores the bus completely.

A read returns the byte at the current pointer, most significant bit first, and advances the pointer after each byte. The controller keeps a read going by acknowledging each byte and ends it with a not-acknowledge. A random read is a pointer-only write followed by a repeated start and a read select.

The state machine has these states: `ST_IDLE` (standby), `ST_DEV` (device byte shifting), `ST_DEV_ACK`, `ST_AHI`/`ST_AHI_ACK` (pointer high byte), `ST_ALO`/`ST_ALO_ACK` (pointer low byte), `ST_WDAT`/`ST_WDAT_ACK` (data byte), `ST_WAIT_STOP` (write armed), `ST_RDAT` (driving a read byte), `ST_RACK` (controller acknowledge slot) and `ST_PROG` (programming).

Outside `ST_PROG`, the transitions are:
- A start moves the machine to `ST_DEV` from any state.
- A stop moves it to `ST_PROG` from `ST_WAIT_STOP`, and to `ST_IDLE` from any other state.
- The eighth clock fall of each received byte moves it to that byte's acknowledge state. In `ST_DEV` a select mismatch sends it to `ST_IDLE` instead.
- The clock fall that ends an acknowledge moves it to the next state:
  - `ST_DEV_ACK` goes to `ST_RDAT` for a read and to `ST_AHI` for a write.
  - `ST_AHI_ACK` goes to `ST_ALO`, `ST_ALO_ACK` to `ST_WDAT`, and `ST_WDAT_ACK` to `ST_WAIT_STOP`.
- The eighth fall in `ST_RDAT` moves it to `ST_RACK`. The next fall moves it back to `ST_RDAT` if the controller acknowledged, and to `ST_IDLE` if it did not.
- `ST_PROG` returns to `ST_IDLE` after `PROG_CYCLES` clocks.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A data-line fall while the clock line is high is a start. It returns the protocol to device-byte reception from any point outside programming, including after a select mismatch or partway through a byte.
- R2: The device byte is `1010`, then select bits 3..1 equal to `chip_sel_i[2:0]`, then bit 0 (1 = read, 0 = write). It is received MSB first. On a match, `sda_pull_o` holds the data line low during the ninth clock-high phase. On a mismatch, the line is left released.
- R3: A write select is followed by the pointer high byte, the pointer low byte and one data byte, and each of them is acknowledged on its ninth clock.
- R4: Memory changes only when a stop (data-line rise while the clock line is high) arrives after the acknowledged data byte. A transfer cut off by a start before that point writes nothing and starts no programming interval.
- R5: After a committing stop, `busy_o` is high for exactly `PROG_CYCLES` system clocks. While it is high, no byte is acknowledged, not even a matching select.
- R6: The pointer takes the low `MEM_AW` bits of the 16-bit address. Higher bits are ignored.
- R7: After an acknowledged read select, the target drives the byte at the pointer MSB first and increments the pointer after each byte. It continues while the controller acknowledges and releases the line after a not-acknowledge.
- R8: After reset, `sda_pull_o` and `busy_o` are 0 and the target is in standby.
- R9: After a committed write, the pointer is the written address plus one, so a read select with no pointer returns the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| chip_sel_i | input | 3 | Pin-strapped select bits compared with device byte bits 3..1 |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| busy_o | output | 1 | High during the programming interval |

## Verification
The bench sets `MEM_AW` to 10, which sits between the two pointer bytes. A pointer such as `0xFC06` therefore lands on `0x006`, and the masking of the upper address bits can be seen through a later read. `PROG_CYCLES` is 1500 system clocks. That is longer than a full select byte at the bench bus rate, so an address attempt can be made entirely inside the busy window. It is still short enough that many committed writes, sequential reads and an aborted write fit in one run. The bench sets `chip_sel_i` to `101`, so both a wrong select code and a wrong type nibble can be shown to go unanswered.

// File: rtl/eep_tgt_pkg.sv
package eep_tgt_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_WAIT_STOP,
        ST_RDAT,
        ST_RACK,
        ST_PROG
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise  = scl && !scl_q;
    assign scl_fall  = !scl && scl_q;
    assign start_evt = scl && scl_q && sda_q && !sda;
    assign stop_evt  = scl && scl_q && !sda_q && sda;
endmodule

// File: rtl/eep_byte_mem.sv
module eep_byte_mem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eep_tgt_pkg::*;
#(
    parameter int MEM_AW      = 10,
    parameter int PROG_CYCLES = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel_i,
    output logic       sda_pull_o,
    output logic       busy_o
);
    localparam int PROG_W = $clog2(PROG_CYCLES + 1);
    localparam int HI_W   = (MEM_AW > 8) ? MEM_AW - 8 : 1;

    // line synchronisers
    logic [1:0] raw_lines, sync_lines;
    logic       scl_s, sda_s;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lines[g]),
            .q     (sync_lines[g])
        );
    end
    assign scl_s = sync_lines[1];
    assign sda_s = sync_lines[0];

    logic scl_rise, scl_fall, start_evt, stop_evt;

    i2c_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_s),
        .sda       (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    tgt_state_t        state, state_d;
    logic [7:0]        shreg, txreg, wdata_q, mem_rdata;
    logic [3:0]        bit_cnt;
    logic [HI_W-1:0]   addr_hi_q;
    logic [MEM_AW-1:0] ptr, load_addr;
    logic [PROG_W-1:0] prog_cnt;
    logic              mack_q, mem_we, byte_done, dev_match, in_rx;

    if (MEM_AW > 8) begin : g_wide
        assign load_addr = {addr_hi_q, shreg};
    end else begin : g_narrow
        assign load_addr = shreg[MEM_AW-1:0];
    end

    assign in_rx     = (state == ST_DEV) || (state == ST_AHI) ||
                       (state == ST_ALO) || (state == ST_WDAT);
    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign dev_match = (shreg[7:1] == {DEV_TYPE, chip_sel_i});
    assign mem_we    = (state == ST_WAIT_STOP) && stop_evt;

    eep_byte_mem #(.AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (wdata_q),
        .rdata (mem_rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        if (state == ST_PROG) begin
            if (prog_cnt == PROG_W'(PROG_CYCLES - 1)) state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = ST_DEV;
        end else if (stop_evt) begin
            state_d = (state == ST_WAIT_STOP) ? ST_PROG : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEV:       if (byte_done) state_d = dev_match ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall)  state_d = shreg[0] ? ST_RDAT : ST_AHI;
                ST_AHI:       if (byte_done) state_d = ST_AHI_ACK;
                ST_AHI_ACK:   if (scl_fall)  state_d = ST_ALO;
                ST_ALO:       if (byte_done) state_d = ST_ALO_ACK;
                ST_ALO_ACK:   if (scl_fall)  state_d = ST_WDAT;
                ST_WDAT:      if (byte_done) state_d = ST_WDAT_ACK;
                ST_WDAT_ACK:  if (scl_fall)  state_d = ST_WAIT_STOP;
                ST_WAIT_STOP: state_d = ST_WAIT_STOP;
                ST_RDAT:      if (scl_fall && bit_cnt == 4'd7) state_d = ST_RACK;
                ST_RACK:      if (scl_fall)  state_d = mack_q ? ST_RDAT : ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            txreg     <= '0;
            wdata_q   <= '0;
            bit_cnt   <= '0;
            addr_hi_q <= '0;
            ptr       <= '0;
            prog_cnt  <= '0;
            mack_q    <= 1'b0;
        end else begin
            if (state_d != state || start_evt) begin
                bit_cnt <= '0;
            end else if (in_rx && scl_rise) begin
                shreg   <= {shreg[6:0], sda_s};
                bit_cnt <= bit_cnt + 4'd1;
            end else if (state == ST_RDAT && scl_fall) begin
                txreg   <= {txreg[6:0], 1'b0};
                bit_cnt <= bit_cnt + 4'd1;
            end

            if (byte_done && state == ST_AHI)  addr_hi_q <= shreg[HI_W-1:0];
            if (byte_done && state == ST_ALO)  ptr       <= load_addr;
            if (byte_done && state == ST_WDAT) wdata_q   <= shreg;

            if (state_d == ST_RDAT && state != ST_RDAT) begin
                txreg <= mem_rdata;
                ptr   <= ptr + 1'b1;
            end
            if (state == ST_RACK && scl_rise) mack_q <= ~sda_s;
            if (mem_we) ptr <= ptr + 1'b1;

            if (state == ST_PROG) prog_cnt <= prog_cnt + 1'b1;
            else                  prog_cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        sda_pull_o = (state == ST_DEV_ACK) || (state == ST_AHI_ACK) ||
                     (state == ST_ALO_ACK) || (state == ST_WDAT_ACK) ||
                     (state == ST_RDAT && !txreg[7]);
        busy_o     = (state == ST_PROG);
    end
endmodule

// File: rtl/eeprom_i2c_target_chk.sv
module eeprom_i2c_target_chk
    import eep_tgt_pkg::*;
#(
    parameter int PROG_CYCLES = 5000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       busy_o,
    input logic       sda_pull_o,
    input tgt_state_t state_q
);
    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_run <= 0;
        else if (busy_o) busy_run <= busy_run + 1;
        else             busy_run <= 0;
    end

    // R1
    start_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !busy_o) |=> (state_q == ST_DEV));

    // R2
    pull_on_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);

    // R4
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_evt));

    // R5
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_pull_o);

    // R5
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_run == PROG_CYCLES));
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .busy_o     (busy_o),
    .sda_pull_o (sda_pull_o),
    .state_q    (state)
);

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_AW     = 10;
    localparam int PROG       = 1500;
    localparam int Q          = 10;
    localparam logic [2:0] PINS  = 3'b101;
    localparam logic [7:0] DEV_W = 8'hAA;
    localparam logic [7:0] DEV_R = 8'hAB;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_d = 1'b1;
    logic sda_pull, busy;
    logic sda_line;
    assign sda_line = sda_d & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_i2c_target #(.MEM_AW(MEM_AW), .PROG_CYCLES(PROG)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .chip_sel_i (PINS),
        .sda_pull_o (sda_pull),
        .busy_o     (busy)
    );

    int n_chk = 0, n_fail = 0, busy_run = 0, last_busy = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$], obs_q[$];
    string tag_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // busy length monitor
    initial forever begin
        @(negedge clk);
        if (busy) busy_run++;
        else begin
            if (busy_run != 0) last_busy = busy_run;
            busy_run = 0;
        end
    end

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        while (obs_q.size() > 0) begin
            logic [7:0] o;
            o = obs_q.pop_front();
            if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected read byte", o, 0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(o == e, t, "read byte", o, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run hung", 0, 1);
        summary();
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_d = 1'b1; wq(); scl = 1'b1; wq(); sda_d = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_d = 1'b0; wq(); scl = 1'b1; wq(); sda_d = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b, output logic seen);
        sda_d = b; wq(); scl = 1'b1; wq(); seen = sda_line; wq(); scl = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rd_byte(input bit mack);
        logic [7:0] d;
        logic s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, s);
            d[i] = s;
        end
        send_bit(!mack, s);
        obs_q.push_back(d);
    endtask

    task automatic expect_rd(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic set_pointer(input logic [15:0] a, input string t);
        bit ack;
        bus_start();
        wr_byte(DEV_W, ack);   chk(ack, t, "select ack", ack, 1);
        wr_byte(a[15:8], ack); chk(ack, t, "addr hi ack", ack, 1);
        wr_byte(a[7:0], ack);  chk(ack, t, "addr lo ack", ack, 1);
    endtask

    task automatic write_mem(input logic [15:0] a, input logic [7:0] v);
        bit ack;
        set_pointer(a, "R3");
        wr_byte(v, ack); chk(ack, "R3", "data ack", ack, 1);
        chk(!busy, "R4", "busy before stop", busy, 0);
        bus_stop();
        chk(busy, "R5", "busy after stop", busy, 1);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(last_busy == PROG, "R5", "busy length", last_busy, PROG);
    endtask

    task automatic read_from(input logic [15:0] a, input int n);
        bit ack;
        set_pointer(a, "R7");
        bus_start();
        wr_byte(DEV_R, ack); chk(ack, "R7", "read select ack", ack, 1);
        for (int i = 0; i < n; i++) rd_byte(i < n - 1);
        bus_stop();
        chk(!sda_pull, "R7", "released after nack", sda_pull, 0);
    endtask

    initial begin
        bit ack;
        logic s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R8
        chk(!sda_pull, "R8", "pull after reset", sda_pull, 0);
        chk(!busy, "R8", "busy after reset", busy, 0);

        // R2 mismatch on select bits, then R1 restart works
        bus_start();
        wr_byte(8'hA6, ack); chk(!ack, "R2", "wrong select acked", ack, 0);
        bus_start();
        wr_byte(8'hBA, ack); chk(!ack, "R2", "wrong type acked", ack, 0);
        bus_start();
        wr_byte(DEV_W, ack); chk(ack, "R1", "select after restart", ack, 1);
        bus_stop();
        chk(!busy, "R4", "no busy after pointerless stop", busy, 0);

        // R3 / R5 first write with a select attempt during busy
        set_pointer(16'h0105, "R3");
        wr_byte(8'hA5, ack); chk(ack, "R3", "data ack", ack, 1);
        bus_stop();
        chk(busy, "R5", "busy after stop", busy, 1);
        bus_start();
        wr_byte(DEV_W, ack); chk(!ack, "R5", "ack while busy", ack, 0);
        bus_stop();
        chk(busy, "R5", "still busy", busy, 1);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(last_busy == PROG, "R5", "busy length", last_busy, PROG);

        // R6 high address bits ignored
        write_mem(16'hFC06, 8'h5A);

        // writes for sequential and current-address reads
        write_mem(16'h0021, 8'h22);
        write_mem(16'h0022, 8'h33);
        write_mem(16'h0020, 8'h11);

        // R9 current-address read
        expect_rd(8'h22, "R9");
        bus_start();
        wr_byte(DEV_R, ack); chk(ack, "R9", "read select ack", ack, 1);
        rd_byte(1'b0);
        bus_stop();

        // R7 sequential read
        expect_rd(8'h11, "R7");
        expect_rd(8'h22, "R7");
        expect_rd(8'h33, "R7");
        read_from(16'h0020, 3);

        expect_rd(8'hA5, "R3");
        read_from(16'h0105, 1);
        expect_rd(8'h5A, "R6");
        read_from(16'h0006, 1);

        // R4 aborted write: start mid data byte
        set_pointer(16'h0020, "R4");
        for (int i = 0; i < 4; i++) send_bit(1'b0, s);
        bus_start();
        bus_stop();
        repeat (40) @(negedge clk);
        chk(!busy, "R4", "busy after aborted write", busy, 0);
        expect_rd(8'h11, "R4");
        read_from(16'h0020, 1);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "pending expected reads", exp_q.size(), 0);
        summary();
    end
endmodule